// File: doc/BRIEF.md
# Scan Chain Device Enumerator

This block is a JTAG master that discovers the devices on a scan chain of unknown make-up. It needs no knowledge of any device's instruction register length. It produces TCK from the system clock and drives TMS and TDI. It forces every TAP on the chain into Test-Logic-Reset, which leaves each device's identification register selected, or its bypass register where no identification register exists. It then walks the chain into Shift-DR and reads the captured data registers out of TDO. Each device is told apart by the first bit it returns. A 1 opens a 32-bit identification code. A 0 is a single-bit bypass register.

TDI is held high for the whole scan, so the chain returns ones once the real devices have all been read out. A full 32-bit field of ones therefore marks the end of the chain. A parameter caps the number of devices the block will report. If a further device shows up, the block raises an overflow flag and stops. When the scan ends, the TAPs are parked in Run-Test/Idle and the block reports the device count.

Results leave on a valid/ready stream. A result word stays on the outputs until the consumer takes it. While a word is waiting, TCK is frozen in its high phase, so no chain data is ever lost to back-pressure. `start`, `busy`, `done` and `overflow` are plain level signals.

Top module: `jtag_chain_scan`

## Requirements
- R1: After reset the block is idle with `busy`=0, `done`=0, `res_valid`=0, `overflow`=0, `tck`=0, `tms`=1 and `tdi`=1.
- R2: Each TCK phase lasts at least max(1, `half_period`) system clocks. `half_period` is latched when `start` is accepted, and a value of 0 acts as 1. With no back-pressure, the shortest phase is exactly that length.
- R3: A scan begins with at least five TCK rising edges at TMS=1, which reaches Test-Logic-Reset from any TAP state. It then presents TMS 0,1,0,0 to reach Shift-DR. The scan passes through Capture-DR exactly once and never enters any instruction-register state.
- R4: TMS changes only together with a falling TCK edge, or while TCK is low when a scan starts. TDO is sampled on rising TCK edges.
- R5: TDI stays at 1 throughout.
- R6: A device whose first bit is 1 is reported with `res_bypass`=0. Its `res_code` holds that bit and the following 31 bits, least significant bit first, so the first bit lands in bit 0.
- R7: A device whose first bit is 0 is reported as a single bypass entry with `res_bypass`=1 and `res_code`=0. The very next bit starts the next device.
- R8: A 32-bit field that reads as all ones ends the scan and is not reported. An empty chain yields no results.
- R9: Results appear in chain order, with the device nearest TDO first. While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_bypass` and `res_code` hold steady. TCK does not toggle while a result is pending.
- R10: A device found after `MAX_DEV` devices have been reported is not reported. It sets `overflow`=1 and ends the scan. A chain of exactly `MAX_DEV` devices gives no overflow.
- R11: After the last bit, TMS 1,1,0 brings the TAPs to Run-Test/Idle. On the following TCK fall, `busy` drops and `done` rises in the same cycle. TCK is low whenever the block is not busy. `done` and `dev_count` (the number of reported devices) hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; accepted only while idle |
| half_period | input | DIV_W | System clocks per TCK phase (0 acts as 1) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last scan finished and TAPs parked in Run-Test/Idle |
| overflow | output | 1 | Last scan stopped at the device cap |
| dev_count | output | $clog2(MAX_DEV+1) | Devices reported in the last scan |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result word |
| res_bypass | output | 1 | Result is a bypassed device |
| res_code | output | 32 | Identification code, zero for bypass |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
The assertions assume that `tdo` is stable around each rising TCK edge, which holds when every device updates it only after a falling edge. They also assume that `start` matters only while idle. The stimulus meets both conditions. A behavioural TAP chain changes TDO only on falling TCK edges, and `start` is pulsed only after `done`. `res_ready` is left free and is driven with both steady and sparse patterns, so the hold and freeze properties are exercised under real back-pressure.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;
  localparam int unsigned ID_W = 32;

  typedef enum logic [3:0] {
    W_IDLE,
    W_RESET,
    W_TO_RTI,
    W_TO_SEL,
    W_TO_CAP,
    W_TO_SHIFT,
    W_SHIFT,
    W_TO_EXIT,
    W_TO_UPD,
    W_TO_PARK,
    W_PARK
  } walk_e;

  typedef struct packed {
    logic            bypass;
    logic [ID_W-1:0] code;
  } dev_word_t;
endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] half_period,
  output logic             tck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             hit;

  always_comb begin
    lim = (half_period == '0) ? '0 : half_period - 1'b1;
    hit = (cnt >= lim);
    rise_ev = en && hit && !tck;
    fall_ev = en && hit && tck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      if (hit) begin
        cnt <= '0;
        tck <= ~tck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the clock only moves while enabled
  a_r2_tck_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tck) |-> $past(en));
endmodule

// File: rtl/jtag_id_parser.sv
module jtag_id_parser #(
  parameter int unsigned ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            bit_en,
  input  logic            bit_in,
  output logic            dev_found,
  output logic            dev_bypass,
  output logic [ID_W-1:0] dev_code,
  output logic            end_found
);
  localparam int unsigned IW = $clog2(ID_W);

  logic            in_id;
  logic [IW-1:0]   idx;
  logic [ID_W-1:0] sh;
  logic [ID_W-1:0] sh_nxt;
  logic            last;
  logic            all_ones;

  always_comb begin
    sh_nxt     = {bit_in, sh[ID_W-1:1]};
    last       = in_id && (idx == IW'(ID_W - 1));
    all_ones   = &sh_nxt;
    dev_found  = bit_en && ((!in_id && !bit_in) || (last && !all_ones));
    end_found  = bit_en && last && all_ones;
    dev_bypass = !in_id;
    dev_code   = in_id ? sh_nxt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_id <= 1'b0;
      idx   <= '0;
      sh    <= '0;
    end else if (clr) begin
      in_id <= 1'b0;
      idx   <= '0;
      sh    <= '0;
    end else if (bit_en) begin
      sh <= sh_nxt;
      if (!in_id) begin
        if (bit_in) begin
          in_id <= 1'b1;
          idx   <= IW'(1);
        end
      end else if (last) begin
        in_id <= 1'b0;
        idx   <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R8: an end-of-chain field is never also a device
  a_r8_end_not_device: assert property (@(posedge clk) disable iff (!rst_n)
    end_found |-> !dev_found);
  // R7: a zero lead bit outside a code is always a bypass device
  a_r7_zero_is_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !in_id && !bit_in) |-> (dev_found && dev_bypass));
endmodule

// File: rtl/jtag_tap_walker.sv
module jtag_tap_walker
  import jtag_scan_pkg::*;
#(
  parameter int unsigned MAX_DEV     = 16,
  parameter int unsigned RESET_EDGES = 5,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned CNT_W       = $clog2(MAX_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_period,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             dev_found,
  input  logic             dev_bypass,
  input  logic [ID_W-1:0]  dev_code,
  input  logic             end_found,
  input  logic             res_ready,
  output logic [DIV_W-1:0] hp_q,
  output logic             div_en,
  output logic             scan_clr,
  output logic             bit_en,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] dev_count,
  output logic             res_valid,
  output dev_word_t        res_word,
  output logic             tms
);
  localparam int unsigned RW = $clog2(RESET_EDGES + 1);

  walk_e          state;
  logic [RW-1:0]  rst_cnt;
  logic           tms_nxt;

  always_comb begin
    case (state)
      W_RESET, W_TO_SEL, W_TO_EXIT, W_TO_UPD: tms_nxt = 1'b1;
      W_IDLE:                                 tms_nxt = tms;
      default:                                tms_nxt = 1'b0;
    endcase
    div_en   = busy && !res_valid;
    scan_clr = start && (state == W_IDLE);
    bit_en   = rise_ev && (state == W_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      rst_cnt   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      dev_count <= '0;
      res_valid <= 1'b0;
      res_word  <= '0;
      tms       <= 1'b1;
      hp_q      <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (state == W_IDLE) begin
        if (start) begin
          state     <= W_RESET;
          rst_cnt   <= '0;
          busy      <= 1'b1;
          done      <= 1'b0;
          overflow  <= 1'b0;
          dev_count <= '0;
          tms       <= 1'b1;
          hp_q      <= half_period;
        end
      end else if (rise_ev) begin
        case (state)
          W_RESET: begin
            if (rst_cnt == RW'(RESET_EDGES - 1)) state <= W_TO_RTI;
            else rst_cnt <= rst_cnt + 1'b1;
          end
          W_TO_RTI:   state <= W_TO_SEL;
          W_TO_SEL:   state <= W_TO_CAP;
          W_TO_CAP:   state <= W_TO_SHIFT;
          W_TO_SHIFT: state <= W_SHIFT;
          W_SHIFT: begin
            if (end_found) begin
              state <= W_TO_EXIT;
            end else if (dev_found) begin
              if (dev_count == CNT_W'(MAX_DEV)) begin
                overflow <= 1'b1;
                state    <= W_TO_EXIT;
              end else begin
                res_valid <= 1'b1;
                res_word  <= '{bypass: dev_bypass, code: dev_code};
                dev_count <= dev_count + 1'b1;
              end
            end
          end
          W_TO_EXIT: state <= W_TO_UPD;
          W_TO_UPD:  state <= W_TO_PARK;
          W_TO_PARK: state <= W_PARK;
          default:   state <= state;
        endcase
      end else if (fall_ev) begin
        tms <= tms_nxt;
        if (state == W_PARK) begin
          state <= W_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R4: during a scan TMS moves only at a falling test clock edge
  a_r4_tms_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tms)) |-> $past(fall_ev));
  // R9: a pending result word holds until taken
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_word)));
  // R7: bypass entries carry a zero code
  a_r7_bypass_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_word.bypass) |-> (res_word.code == '0));
  // R10: the count never exceeds the cap
  a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    dev_count <= CNT_W'(MAX_DEV));
  // R11: done and busy are exclusive
  a_r11_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: rtl/jtag_chain_scan.sv
module jtag_chain_scan
  import jtag_scan_pkg::*;
#(
  parameter int unsigned MAX_DEV     = 16,
  parameter int unsigned RESET_EDGES = 5,
  parameter int unsigned DIV_W       = 8,
  localparam int unsigned CNT_W      = $clog2(MAX_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_period,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] dev_count,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_bypass,
  output logic [ID_W-1:0]  res_code,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo
);
  logic [DIV_W-1:0] hp_q;
  logic             div_en;
  logic             scan_clr;
  logic             rise_ev;
  logic             fall_ev;
  logic             bit_en;
  logic             dev_found;
  logic             dev_bypass;
  logic [ID_W-1:0]  dev_code;
  logic             end_found;
  dev_word_t        res_word;

  assign tdi        = 1'b1;
  assign res_bypass = res_word.bypass;
  assign res_code   = res_word.code;

  jtag_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (scan_clr),
    .en          (div_en),
    .half_period (hp_q),
    .tck         (tck),
    .rise_ev     (rise_ev),
    .fall_ev     (fall_ev)
  );

  jtag_id_parser #(.ID_W(ID_W)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (scan_clr),
    .bit_en     (bit_en),
    .bit_in     (tdo),
    .dev_found  (dev_found),
    .dev_bypass (dev_bypass),
    .dev_code   (dev_code),
    .end_found  (end_found)
  );

  jtag_tap_walker #(
    .MAX_DEV     (MAX_DEV),
    .RESET_EDGES (RESET_EDGES),
    .DIV_W       (DIV_W),
    .CNT_W       (CNT_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .half_period (half_period),
    .rise_ev     (rise_ev),
    .fall_ev     (fall_ev),
    .dev_found   (dev_found),
    .dev_bypass  (dev_bypass),
    .dev_code    (dev_code),
    .end_found   (end_found),
    .res_ready   (res_ready),
    .hp_q        (hp_q),
    .div_en      (div_en),
    .scan_clr    (scan_clr),
    .bit_en      (bit_en),
    .busy        (busy),
    .done        (done),
    .overflow    (overflow),
    .dev_count   (dev_count),
    .res_valid   (res_valid),
    .res_word    (res_word),
    .tms         (tms)
  );

  // R9: the test clock is frozen while a word waits
  a_r9_tck_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> $stable(tck));
  // R11: the test clock rests low when idle
  a_r11_tck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
endmodule

// File: tb/test_jtag_chain_scan.sv
module test_jtag_chain_scan;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD       = 16;

  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SDR, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR,
    T_UDR, T_SIR, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
  } ts_e;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  half_period = 8'd1;
  logic        res_ready = 1'b0;
  logic        tdo = 1'b0;
  logic        busy, done, overflow, res_valid, res_bypass, tck, tms, tdi;
  logic [4:0]  dev_count;
  logic [31:0] res_code;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_chain_scan i_jtag_chain_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .busy(busy), .done(done), .overflow(overflow), .dev_count(dev_count),
    .res_valid(res_valid), .res_ready(res_ready), .res_bypass(res_bypass),
    .res_code(res_code), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // ---------------- behavioural chain ----------------
  ts_e          mst = T_PDR;
  logic [1023:0] msr = '1;
  logic [1023:0] mload = '1;
  int           cap_cnt = 0;
  int           ir_cnt = 0;
  bit           tlr_seen = 0;
  int           tdi_low = 0;

  function automatic ts_e tap_next(ts_e s, logic m);
    case (s)
      T_TLR:  return m ? T_TLR  : T_RTI;
      T_RTI:  return m ? T_SDR  : T_RTI;
      T_SDR:  return m ? T_SIR  : T_CDR;
      T_CDR:  return m ? T_E1DR : T_SHDR;
      T_SHDR: return m ? T_E1DR : T_SHDR;
      T_E1DR: return m ? T_UDR  : T_PDR;
      T_PDR:  return m ? T_E2DR : T_PDR;
      T_E2DR: return m ? T_UDR  : T_SHDR;
      T_UDR:  return m ? T_SDR  : T_RTI;
      T_SIR:  return m ? T_TLR  : T_CIR;
      T_CIR:  return m ? T_E1IR : T_SHIR;
      T_SHIR: return m ? T_E1IR : T_SHIR;
      T_E1IR: return m ? T_UIR  : T_PIR;
      T_PIR:  return m ? T_E2IR : T_PIR;
      T_E2IR: return m ? T_UIR  : T_SHIR;
      default: return m ? T_SDR : T_RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (tdi !== 1'b1) tdi_low++;
    if (mst == T_SHDR) msr = {tdi, msr[1023:1]};
    if (mst == T_CDR) begin msr = mload; cap_cnt++; end
    if (mst == T_SHIR || mst == T_CIR) ir_cnt++;
    if (tap_next(mst, tms) == T_TLR && cap_cnt == 0) tlr_seen = 1;
    mst = tap_next(mst, tms);
  end

  always @(negedge tck) tdo <= (mst == T_SHDR) ? msr[0] : 1'b0;

  // ---------------- pin monitors ----------------
  logic prev_tck = 1'b0;
  logic prev_tms = 1'b1;
  int   run = 0;
  int   min_ph = 1000000;
  int   tms_bad = 0;

  always @(negedge clk) begin
    if (busy) begin
      if (tck !== prev_tck) begin
        if (run > 0 && run < min_ph) min_ph = run;
        run = 1;
      end else run++;
      if (tms !== prev_tms && tck === 1'b1) tms_bad++;
    end else run = 0;
    prev_tck = tck;
    prev_tms = tms;
  end

  // ---------------- scenario data ----------------
  bit          dv_byp[0:23];
  logic [31:0] dv_code[0:23];
  int          n_dev = 0;
  bit          got_byp[0:23];
  logic [31:0] got_code[0:23];
  int          got_n = 0;
  int          hold_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_dev(input int i, input bit byp, input logic [31:0] code);
    dv_byp[i] = byp;
    dv_code[i] = code;
  endtask

  task automatic run_scan(input string name, input int hp, input bit stall);
    int pos;
    int k;
    int exp_n;
    int hp_eff;
    bit pv, pr;
    logic ptck;
    logic [32:0] pw;
    mload = '1;
    pos = 0;
    for (int i = 0; i < n_dev; i++) begin
      if (dv_byp[i]) begin mload[pos] = 1'b0; pos += 1; end
      else begin mload[pos +: 32] = dv_code[i]; pos += 32; end
    end
    mst = T_PDR; cap_cnt = 0; ir_cnt = 0; tlr_seen = 0; tdi_low = 0;
    min_ph = 1000000; tms_bad = 0; got_n = 0; hold_bad = 0;
    pv = 0; pr = 0; ptck = 0; pw = '0;
    @(negedge clk);
    half_period = 8'(hp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 60000) begin
      res_ready = stall ? (k % 4 == 3) : 1'b1;
      if (pv) begin
        if (tck !== ptck) hold_bad++;
        if (!pr && (!res_valid || {res_bypass, res_code} !== pw)) hold_bad++;
      end
      if (res_valid && res_ready && got_n < 24) begin
        got_byp[got_n] = res_bypass;
        got_code[got_n] = res_code;
        got_n++;
      end
      pv = res_valid; pr = res_ready; pw = {res_bypass, res_code}; ptck = tck;
      k++;
      @(negedge clk);
    end
    res_ready = 1'b0;
    exp_n = (n_dev > MAXD) ? MAXD : n_dev;
    hp_eff = (hp < 1) ? 1 : hp;
    chk(k < 60000, "R11", {name, " scan finished"}, k, 0);
    chk(got_n == exp_n, "R8", {name, " result count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (dv_byp[i]) begin
        chk(got_byp[i] == 1'b1 && got_code[i] == 32'h0, "R7",
            {name, " bypass entry"}, {got_byp[i], got_code[i]}, {1'b1, 32'h0});
      end else begin
        chk(got_byp[i] == 1'b0 && got_code[i] == dv_code[i], "R6",
            {name, " id entry"}, {got_byp[i], got_code[i]}, {1'b0, dv_code[i]});
      end
    end
    chk(overflow == (n_dev > MAXD), "R10", {name, " overflow"}, overflow, n_dev > MAXD);
    chk(dev_count == exp_n, "R11", {name, " dev_count"}, dev_count, exp_n);
    chk(!busy && done && !tck, "R11", {name, " idle flags"}, {busy, done, tck}, 3'b010);
    chk(mst == T_RTI, "R11", {name, " chain parked"}, mst, T_RTI);
    chk(tlr_seen && cap_cnt == 1 && ir_cnt == 0, "R3", {name, " reset path"},
        {tlr_seen, 8'(cap_cnt), 8'(ir_cnt)}, {1'b1, 8'd1, 8'd0});
    chk(tms_bad == 0, "R4", {name, " tms moved with tck high"}, tms_bad, 0);
    chk(tdi_low == 0 && tdi === 1'b1, "R5", {name, " tdi level"}, tdi_low, 0);
    chk(hold_bad == 0, "R9", {name, " stream hold"}, hold_bad, 0);
    chk(min_ph == hp_eff, "R2", {name, " shortest phase"}, min_ph, hp_eff);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk(!busy && !done && !res_valid && !overflow, "R1", "reset flags",
        {busy, done, res_valid, overflow}, 4'b0000);
    chk(tck == 1'b0 && tms == 1'b1 && tdi == 1'b1, "R1", "reset pins",
        {tck, tms, tdi}, 3'b011);
  endtask

  task automatic t_mixed_chain();
    n_dev = 6;
    set_dev(0, 0, 32'h0BA0_0477);
    set_dev(1, 1, 32'h0);
    set_dev(2, 1, 32'h0);
    set_dev(3, 0, 32'hFFFF_FFFD);
    set_dev(4, 0, 32'h7FFF_FFFF);
    set_dev(5, 1, 32'h0);
    run_scan("mixed", 2, 0);
    repeat (20) @(negedge clk);
    chk(done && dev_count == 6, "R11", "done held after scan", {done, dev_count}, {1'b1, 5'd6});
  endtask

  task automatic t_empty_chain();
    n_dev = 0;
    run_scan("empty", 1, 0);
  endtask

  task automatic t_backpressure();
    n_dev = 4;
    set_dev(0, 0, 32'h1234_5679);
    set_dev(1, 1, 32'h0);
    set_dev(2, 0, 32'h0000_0001);
    set_dev(3, 0, 32'hCAFE_F00D);
    run_scan("stall", 3, 1);
  endtask

  task automatic t_exact_cap();
    n_dev = MAXD;
    for (int i = 0; i < MAXD; i++)
      set_dev(i, (i % 3) == 1, 32'h00A0_0001 | (32'(i) << 4));
    run_scan("cap", 0, 0);
  endtask

  task automatic t_overflow();
    n_dev = MAXD + 2;
    for (int i = 0; i < MAXD + 2; i++)
      set_dev(i, (i % 2) == 0, 32'h5500_0001 | (32'(i) << 8));
    run_scan("overflow", 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_mixed_chain();
    t_empty_chain();
    t_backpressure();
    t_exact_cap();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule